// File: doc/BRIEF.md
# Windowed Register File with Window Pointer Control

This block is an integer register file whose visible registers slide across a larger physical store. Software sees 32 registers at any moment: eight globals shared by every window, and for the current window, eight outgoing, eight local and eight incoming registers. Storage is shared between neighbouring windows. The outgoing registers of window N are the same physical words as the incoming registers of window N-1 (mod NW). A caller can therefore leave arguments in its outgoing registers and the callee finds them in its incoming registers once it has moved to the next window, and no data is copied.

A save request moves the window pointer down by one and a restore request moves it up by one, both modulo NW. A per-window invalid mask is given as an input. If the window a move would land on is marked invalid, the move is refused and a one-cycle overflow (save) or underflow (restore) flag is raised instead. The file has two single-word read ports, one write port, and one doubleword read port. The write port can also write a doubleword. A doubleword access works on an even/odd register pair.

Top module: `wrf_top`

## Requirements
- R1: After reset the window pointer is 0, both flags are low, and every register reads zero.
- R2: A save request alone, whose target window (cwp-1) mod NW has mask bit 0, sets the pointer to that target at the next clock edge. Window 0 goes to window NW-1.
- R3: A restore request alone, whose target window (cwp+1) mod NW has mask bit 0, sets the pointer to that target at the next clock edge. Window NW-1 goes to window 0.
- R4: If a save targets a window whose mask bit is 1, the pointer keeps its value and `overflow` is high for exactly the one cycle after the request edge.
- R5: If a restore targets a window whose mask bit is 1, the pointer keeps its value and `underflow` is high for exactly the one cycle after the request edge.
- R6: When save and restore are requested in the same cycle, neither takes effect and no flag is raised, whatever the mask holds.
- R7: Register numbers 0-7 address globals that read the same from every window. Numbers 16-23 address locals that are private to each window.
- R8: Registers 24-31 (incoming) of window c are the same storage as registers 8-15 (outgoing) of window (c+1) mod NW, in the same order.
- R9: Register 0 always reads zero. Writes to it are dropped, whether they are single or part of a doubleword.
- R10: A doubleword access uses base = selector with bit 0 cleared. `dbl_rd_data` is {reg[base], reg[base+1]}. A doubleword write puts `wr_data_hi` into reg[base] and `wr_data` into reg[base+1].
- R11: Reads are combinational and use the current pointer. A write is visible after the next edge. A write issued in the same cycle as a save goes to the window that was current before the move.
- R12: Only the mask bit of the target window decides overflow or underflow. Mask bits of other windows have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| save_req | input | 1 | Move to the next lower window |
| restore_req | input | 1 | Move to the next higher window |
| inval_mask | input | NW | One bit per window, 1 = invalid |
| cwp | output | CW | Current window pointer |
| overflow | output | 1 | Save refused (one-cycle pulse) |
| underflow | output | 1 | Restore refused (one-cycle pulse) |
| rd_a_sel | input | 5 | Register number for read port A |
| rd_a_data | output | W | Read port A data |
| rd_b_sel | input | 5 | Register number for read port B |
| rd_b_data | output | W | Read port B data |
| dbl_rd_sel | input | 5 | Register number for doubleword read |
| dbl_rd_data | output | 2*W | {even, odd} pair data |
| wr_en | input | 1 | Write enable |
| wr_dbl | input | 1 | Write a doubleword pair |
| wr_sel | input | 5 | Register number to write |
| wr_data | input | W | Single word, or the odd word of a pair |
| wr_data_hi | input | W | Even word of a pair |

## Verification
Read data is combinational, so the bench changes the selectors and samples one time step later, with no clock edge in between. Pointer moves, writes and both flags are registered. Each of them is checked one step after the first rising edge that follows the request, and the flags are checked again after one more idle edge to confirm that they last one cycle. The bench drives inputs one time unit after the rising edge and reads the results before the next edge, so every sample lands a fixed, known number of edges after its stimulus.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

    // Register group decoded from bits [4:3] of a register number
    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_grp_e;

    localparam int unsigned REGS_PER_GRP = 8;
    localparam int unsigned BANK_WORDS   = 16;   // shared in/out + locals

    function automatic int unsigned phys_depth(input int unsigned nw);
        return REGS_PER_GRP + BANK_WORDS * nw;
    endfunction

endpackage

// File: rtl/wrf_window_ctl.sv
module wrf_window_ctl #(
    parameter int unsigned NW = 8,
    localparam int unsigned CW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_req,
    input  logic          restore_req,
    input  logic [NW-1:0] inval_mask,
    output logic [CW-1:0] cwp,
    output logic          overflow,
    output logic          underflow
);

    typedef struct packed {
        logic [CW-1:0] cwp;
        logic          ovf;
        logic          unf;
    } win_state_t;

    win_state_t st_d, st_q;
    logic [CW-1:0] cwp_dn, cwp_up;

    always_comb begin
        cwp_dn = st_q.cwp - 1'b1;
        cwp_up = st_q.cwp + 1'b1;
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        case ({save_req, restore_req})
            2'b10: begin
                if (inval_mask[cwp_dn]) st_d.ovf = 1'b1;
                else                    st_d.cwp = cwp_dn;
            end
            2'b01: begin
                if (inval_mask[cwp_up]) st_d.unf = 1'b1;
                else                    st_d.cwp = cwp_up;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp       = st_q.cwp;
    assign overflow  = st_q.ovf;
    assign underflow = st_q.unf;

    // R2: accepted save moves the pointer down by one
    a_r2_save_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && !inval_mask[CW'(cwp - 1'b1)])
        |=> (cwp == CW'($past(cwp) - 1'b1)) && !overflow);

    // R3: accepted restore moves the pointer up by one
    a_r3_restore_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && !inval_mask[CW'(cwp + 1'b1)])
        |=> (cwp == CW'($past(cwp) + 1'b1)) && !underflow);

    // R4: refused save holds the pointer and flags overflow
    a_r4_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && !restore_req && inval_mask[CW'(cwp - 1'b1)])
        |=> overflow && $stable(cwp));

    // R5: refused restore holds the pointer and flags underflow
    a_r5_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_req && !save_req && inval_mask[CW'(cwp + 1'b1)])
        |=> underflow && $stable(cwp));

    // R6: simultaneous requests do nothing
    a_r6_both_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (save_req && restore_req) |=> $stable(cwp) && !overflow && !underflow);

    // R4, R5: flags never coexist
    a_r4_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(overflow && underflow));

endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
    import wrf_pkg::*;
#(
    parameter int unsigned NW = 8,
    localparam int unsigned CW = (NW > 1) ? $clog2(NW) : 1,
    localparam int unsigned DEPTH = phys_depth(NW),
    localparam int unsigned PW = $clog2(DEPTH)
) (
    input  logic [CW-1:0] cwp,
    input  logic [4:0]    arch,
    output logic [PW-1:0] phys
);

    reg_grp_e      grp;
    logic [CW-1:0] bank;
    logic [PW-1:0] bank_base;
    logic [PW-1:0] grp_off;

    always_comb begin
        grp  = reg_grp_e'(arch[4:3]);
        // incoming registers live in the next higher window's bank
        bank = (grp == GRP_IN) ? CW'(cwp + 1'b1) : cwp;
        bank_base = PW'(REGS_PER_GRP) + (PW'(bank) << 4);
        grp_off   = (grp == GRP_LOCAL) ? PW'(REGS_PER_GRP) : '0;
        if (grp == GRP_GLOBAL) phys = PW'(arch[2:0]);
        else                   phys = bank_base + grp_off + PW'(arch[2:0]);
    end

endmodule

// File: rtl/wrf_storage.sv
module wrf_storage #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 136,
    parameter int unsigned NR    = 4,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we0,
    input  logic [AW-1:0]         wa0,
    input  logic [W-1:0]          wd0,
    input  logic                  we1,
    input  logic [AW-1:0]         wa1,
    input  logic [W-1:0]          wd1,
    input  logic [NR-1:0][AW-1:0] raddr,
    output logic [NR-1:0][W-1:0]  rdata
);

    logic [W-1:0] mem_d [DEPTH];
    logic [W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) mem_d[i] = mem_q[i];
        if (we0 && int'(wa0) < DEPTH) mem_d[wa0] = wd0;
        if (we1 && int'(wa1) < DEPTH) mem_d[wa1] = wd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar g = 0; g < NR; g++) begin : g_rd
        assign rdata[g] = (int'(raddr[g]) < DEPTH) ? mem_q[raddr[g]] : '0;
    end

    // R10: the two write ports of a pair never hit the same word
    a_r10_distinct_writes: assert property (@(posedge clk) disable iff (!rst_n)
        (we0 && we1) |-> (wa0 != wa1));

endmodule

// File: rtl/wrf_top.sv
module wrf_top
    import wrf_pkg::*;
#(
    parameter int unsigned NW = 8,
    parameter int unsigned W  = 32,
    localparam int unsigned CW    = (NW > 1) ? $clog2(NW) : 1,
    localparam int unsigned DEPTH = phys_depth(NW),
    localparam int unsigned PW    = $clog2(DEPTH),
    localparam int unsigned NMAP  = 7,
    localparam int unsigned NRD   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           save_req,
    input  logic           restore_req,
    input  logic [NW-1:0]  inval_mask,
    output logic [CW-1:0]  cwp,
    output logic           overflow,
    output logic           underflow,
    input  logic [4:0]     rd_a_sel,
    output logic [W-1:0]   rd_a_data,
    input  logic [4:0]     rd_b_sel,
    output logic [W-1:0]   rd_b_data,
    input  logic [4:0]     dbl_rd_sel,
    output logic [2*W-1:0] dbl_rd_data,
    input  logic           wr_en,
    input  logic           wr_dbl,
    input  logic [4:0]     wr_sel,
    input  logic [W-1:0]   wr_data,
    input  logic [W-1:0]   wr_data_hi
);

    // map slots
    localparam int unsigned M_RDA = 0;
    localparam int unsigned M_RDB = 1;
    localparam int unsigned M_DBE = 2;
    localparam int unsigned M_DBO = 3;
    localparam int unsigned M_WR  = 4;
    localparam int unsigned M_WRE = 5;
    localparam int unsigned M_WRO = 6;

    logic [NMAP-1:0][4:0]    arch_sel;
    logic [NMAP-1:0][PW-1:0] phys_idx;
    logic [NRD-1:0][PW-1:0]  rd_addr;
    logic [NRD-1:0][W-1:0]   rd_word;
    logic [4:0]              rd_pair_base;
    logic [4:0]              wr_pair_base;
    logic                    we0, we1;
    logic [PW-1:0]           wa0, wa1;
    logic [W-1:0]            wd0, wd1;

    wrf_window_ctl #(.NW(NW)) u_win (
        .clk         (clk),
        .rst_n       (rst_n),
        .save_req    (save_req),
        .restore_req (restore_req),
        .inval_mask  (inval_mask),
        .cwp         (cwp),
        .overflow    (overflow),
        .underflow   (underflow)
    );

    always_comb begin
        rd_pair_base    = {dbl_rd_sel[4:1], 1'b0};
        wr_pair_base    = {wr_sel[4:1], 1'b0};
        arch_sel[M_RDA] = rd_a_sel;
        arch_sel[M_RDB] = rd_b_sel;
        arch_sel[M_DBE] = rd_pair_base;
        arch_sel[M_DBO] = rd_pair_base | 5'd1;
        arch_sel[M_WR]  = wr_sel;
        arch_sel[M_WRE] = wr_pair_base;
        arch_sel[M_WRO] = wr_pair_base | 5'd1;
    end

    for (genvar g = 0; g < NMAP; g++) begin : g_map
        wrf_addr_map #(.NW(NW)) u_map (
            .cwp  (cwp),
            .arch (arch_sel[g]),
            .phys (phys_idx[g])
        );
    end

    always_comb begin
        rd_addr[0] = phys_idx[M_RDA];
        rd_addr[1] = phys_idx[M_RDB];
        rd_addr[2] = phys_idx[M_DBE];
        rd_addr[3] = phys_idx[M_DBO];
        // port 0: single word or even half; r0 never written
        if (wr_dbl) begin
            we0 = wr_en && (wr_pair_base != 5'd0);
            wa0 = phys_idx[M_WRE];
            wd0 = wr_data_hi;
        end else begin
            we0 = wr_en && (wr_sel != 5'd0);
            wa0 = phys_idx[M_WR];
            wd0 = wr_data;
        end
        // port 1: odd half of a pair
        we1 = wr_en && wr_dbl;
        wa1 = phys_idx[M_WRO];
        wd1 = wr_data;
    end

    wrf_storage #(.W(W), .DEPTH(DEPTH), .NR(NRD)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we0   (we0),
        .wa0   (wa0),
        .wd0   (wd0),
        .we1   (we1),
        .wa1   (wa1),
        .wd1   (wd1),
        .raddr (rd_addr),
        .rdata (rd_word)
    );

    assign rd_a_data   = rd_word[0];
    assign rd_b_data   = rd_word[1];
    assign dbl_rd_data = {rd_word[2], rd_word[3]};

    // R9: register 0 reads zero through the storage on every port
    a_r9_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == 5'd0) |-> (rd_a_data == '0));

    // R10: even half of the pair port agrees with single port A
    a_r10_pair_even: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == rd_pair_base) |-> (dbl_rd_data[2*W-1:W] == rd_a_data));

    // R10: odd half of the pair port agrees with single port B
    a_r10_pair_odd: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_b_sel == (rd_pair_base | 5'd1)) |-> (dbl_rd_data[W-1:0] == rd_b_data));

    // R7: globals read alike on both ports whatever the window
    a_r7_global_ports: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_sel == rd_b_sel) |-> (rd_a_data == rd_b_data));

endmodule

// File: tb/tb_wrf_top.sv
`timescale 1ns/1ps
module tb_wrf_top;
    localparam int NW = 8;
    localparam int W  = 32;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic save_req = 0, restore_req = 0;
    logic [NW-1:0] inval_mask = '0;
    logic [CW-1:0] cwp;
    logic overflow, underflow;
    logic [4:0] rd_a_sel = 0, rd_b_sel = 0, dbl_rd_sel = 0, wr_sel = 0;
    logic [W-1:0] rd_a_data, rd_b_data, wr_data = 0, wr_data_hi = 0;
    logic [2*W-1:0] dbl_rd_data;
    logic wr_en = 0, wr_dbl = 0;

    int n_run = 0, n_fail = 0;
    int cwp_m = 0;

    always #2.5 clk = ~clk;

    wrf_top #(.NW(NW), .W(W)) dut (
        .clk(clk), .rst_n(rst_n), .save_req(save_req), .restore_req(restore_req),
        .inval_mask(inval_mask), .cwp(cwp), .overflow(overflow), .underflow(underflow),
        .rd_a_sel(rd_a_sel), .rd_a_data(rd_a_data), .rd_b_sel(rd_b_sel),
        .rd_b_data(rd_b_data), .dbl_rd_sel(dbl_rd_sel), .dbl_rd_data(dbl_rd_data),
        .wr_en(wr_en), .wr_dbl(wr_dbl), .wr_sel(wr_sel), .wr_data(wr_data),
        .wr_data_hi(wr_data_hi)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] v_out(input int c, input int k);
        return {8'hA0, 8'(c), 8'(k), 8'h11};
    endfunction
    function automatic logic [W-1:0] v_loc(input int c, input int k);
        return {8'hB0, 8'(c), 8'(k), 8'h22};
    endfunction
    function automatic logic [W-1:0] v_glb(input int k);
        return 32'h6000_0000 | k;
    endfunction

    task automatic wr1(input int sel, input logic [W-1:0] d);
        wr_en = 1; wr_dbl = 0; wr_sel = 5'(sel); wr_data = d;
        tick();
        wr_en = 0;
    endtask

    task automatic wr2(input int sel, input logic [W-1:0] hi, input logic [W-1:0] lo);
        wr_en = 1; wr_dbl = 1; wr_sel = 5'(sel); wr_data = lo; wr_data_hi = hi;
        tick();
        wr_en = 0; wr_dbl = 0;
    endtask

    task automatic rd2(input int a, input int b);
        rd_a_sel = 5'(a); rd_b_sel = 5'(b);
        #1;
    endtask

    task automatic do_save();
        save_req = 1; tick(); save_req = 0;
    endtask
    task automatic do_restore();
        restore_req = 1; tick(); restore_req = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL R1 watchdog expired actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [W-1:0] x;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1: reset state
        chk("R1 cwp", 64'(cwp), 64'd0);
        chk("R1 overflow", 64'(overflow), 64'd0);
        chk("R1 underflow", 64'(underflow), 64'd0);
        for (int r = 0; r < 32; r++) begin
            rd2(r, r);
            chk("R1 reg zero", 64'(rd_a_data), 64'd0);
        end

        // R9: writes to r0 dropped
        wr1(0, 32'hFFFF_FFFF);
        rd2(0, 0);
        chk("R9 r0 single write", 64'(rd_a_data), 64'd0);

        // globals
        for (int k = 1; k < 8; k++) wr1(k, v_glb(k));

        // R2, R11: fill each window then save (wrap 0 -> 7)
        for (int s = 0; s < NW; s++) begin
            for (int k = 0; k < 8; k++) begin
                wr1(8 + k, v_out(cwp_m, k));
                wr1(16 + k, v_loc(cwp_m, k));
            end
            do_save();
            cwp_m = (cwp_m + NW - 1) % NW;
            chk("R2 save moves", 64'(cwp), 64'(cwp_m));
            chk("R2 no overflow", 64'(overflow), 64'd0);
        end

        // R3, R7, R8: read back every window, moving by restore
        for (int s = 0; s < NW; s++) begin
            for (int k = 0; k < 8; k++) begin
                rd2(8 + k, 24 + k);
                chk("R11 outs of window", 64'(rd_a_data), 64'(v_out(cwp_m, k)));
                chk("R8 ins are next window outs", 64'(rd_b_data),
                    64'(v_out((cwp_m + 1) % NW, k)));
                rd2(16 + k, k);
                chk("R7 private locals", 64'(rd_a_data), 64'(v_loc(cwp_m, k)));
                chk("R7 shared globals", 64'(rd_b_data), (k == 0) ? 64'd0 : 64'(v_glb(k)));
            end
            do_restore();
            cwp_m = (cwp_m + 1) % NW;
            chk("R3 restore moves", 64'(cwp), 64'(cwp_m));
            chk("R3 no underflow", 64'(underflow), 64'd0);
        end

        // R11: write in the same cycle as save uses the old window
        x = 32'hC0DE_0016;
        wr_en = 1; wr_sel = 5'd16; wr_data = x; save_req = 1;
        tick();
        wr_en = 0; save_req = 0;
        chk("R11 save with write cwp", 64'(cwp), 64'd7);
        rd2(16, 16);
        chk("R11 new window untouched", 64'(rd_a_data), 64'(v_loc(7, 0)));
        do_restore();
        rd2(16, 16);
        chk("R11 write landed in old window", 64'(rd_a_data), 64'(x));

        // R4: save blocked by target mask bit
        inval_mask = 8'h80;
        do_save();
        chk("R4 overflow pulse", 64'(overflow), 64'd1);
        chk("R4 no underflow", 64'(underflow), 64'd0);
        chk("R4 cwp held", 64'(cwp), 64'd0);
        tick();
        chk("R4 overflow one cycle", 64'(overflow), 64'd0);

        // R12: other mask bits do not block
        inval_mask = 8'h7F;
        do_save();
        chk("R12 save allowed", 64'(cwp), 64'd7);
        chk("R12 no overflow", 64'(overflow), 64'd0);
        inval_mask = 8'hFE;
        do_restore();
        chk("R12 restore allowed", 64'(cwp), 64'd0);
        chk("R12 no underflow", 64'(underflow), 64'd0);

        // R5: restore blocked
        inval_mask = 8'h02;
        do_restore();
        chk("R5 underflow pulse", 64'(underflow), 64'd1);
        chk("R5 no overflow", 64'(overflow), 64'd0);
        chk("R5 cwp held", 64'(cwp), 64'd0);
        tick();
        chk("R5 underflow one cycle", 64'(underflow), 64'd0);

        // R6: both requests at once
        inval_mask = 8'hFF;
        save_req = 1; restore_req = 1;
        tick();
        save_req = 0; restore_req = 0;
        chk("R6 cwp held", 64'(cwp), 64'd0);
        chk("R6 no overflow", 64'(overflow), 64'd0);
        chk("R6 no underflow", 64'(underflow), 64'd0);
        inval_mask = 8'h00;
        save_req = 1; restore_req = 1;
        tick();
        save_req = 0; restore_req = 0;
        chk("R6 valid mask cwp held", 64'(cwp), 64'd0);

        // R10: doubleword with odd selector writes the pair ending there
        wr2(17, 32'hAAAA_0001, 32'h5555_0002);
        rd2(16, 17);
        chk("R10 even word", 64'(rd_a_data), 64'h0000_0000_AAAA_0001);
        chk("R10 odd word", 64'(rd_b_data), 64'h0000_0000_5555_0002);
        dbl_rd_sel = 5'd17; #1;
        chk("R10 pair read odd sel", dbl_rd_data, 64'hAAAA_0001_5555_0002);
        dbl_rd_sel = 5'd16; #1;
        chk("R10 pair read even sel", dbl_rd_data, 64'hAAAA_0001_5555_0002);
        dbl_rd_sel = 5'd25; #1;
        chk("R10 pair across ins", dbl_rd_data, {v_out(1, 0), v_out(1, 1)});

        // R9: pair write covering r0
        wr2(1, 32'hDEAD_BEEF, 32'h1234_5678);
        dbl_rd_sel = 5'd0; #1;
        chk("R9 r0 pair write dropped", dbl_rd_data, 64'h0000_0000_1234_5678);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule